// File: doc/BRIEF.md
# Overcurrent and Soft-Start Fault Supervisor

This block supervises the start-up ramp and the overcurrent protection of a switching power controller in digital form. A saturating counter stands in for the soft-start capacitor voltage: it climbs at a fixed charge step until it reaches a clamp value, and the error-amplifier limit follows it. Two comparator flags come in from the current-sense path. The lower-threshold flag means cycle-by-cycle limiting is active. The higher-threshold flag means a hard short.

Sustained cycle-by-cycle limiting, while the start-up sequence is enabled, drops the level to a timer base value and then integrates it upward. If the level reaches the latch threshold, the block locks out all power outputs until the system is reset. A short bypasses the timer. It raises a short-detect flag and drains the level quickly. Once the level reaches the low threshold the flag clears and a fresh soft start begins. A system-off condition (not ready, remote off) drains the level, clears every fault, and forces the next start to begin from soft start.

Thresholds are in counter units. With the default scale of 1 LSB per mV, the clamp is 4000, the latch threshold 3900, the timer base 3780 and the low threshold 400.

Top module: `ocp_ss_supervisor`

## Requirements
- R1: After a synchronous active-low reset, ss_level is 0, lockout and short_det are 0, and discharge is 1.
- R2: While sys_off is high, each clock lowers ss_level by DISCH_STEP, with a floor of 0, and holds discharge at 1 and lockout and short_det at 0. This applies from any state. When sys_off goes low, the next clock enters the ramp with the level unchanged.
- R3: During the ramp, each clock raises ss_level by CHARGE_STEP, saturating at SS_TOP. ss_level never exceeds SS_TOP. One clock after the level reaches SS_TOP, the block enters the clamped state.
- R4: If oneshot_flag is high in the ramp, clamped or timer state, short_det and discharge are 1 from the next clock. ss_level then falls by DISCH_STEP per clock, with a floor of 0.
- R5: short_det stays 1, ignoring all flags, until a clock finds ss_level <= LOW_TH. That clock clears short_det and discharge, holds the level, and restarts the ramp from that level.
- R6: In the clamped state with pbp_flag and seq_en both high, the next clock loads ss_level with TMR_BASE. Each following clock in which both stay high, and the level is below LATCH_TH, adds TMR_STEP.
- R7: In the timer state, if pbp_flag or seq_en is low, the next clock returns ss_level to SS_TOP in the clamped state, without lockout.
- R8: In the timer state, with pbp_flag and seq_en high, a clock that finds ss_level >= LATCH_TH sets lockout. While lockout is set, ss_level is frozen and pbp_flag, oneshot_flag and seq_en have no effect.
- R9: Lockout is cleared only by sys_off or rst_n. It is not cleared by the current flags going low.
- R10: While seq_en is low, pbp_flag never starts or continues integration and never sets lockout. ss_level stays at SS_TOP in the clamped state.
- R11: When oneshot_flag and pbp_flag are high together, the one-shot path wins: short_det is set and integration does not start.
- R12: pbp_flag during the ramp, below SS_TOP, has no effect. The level keeps rising by CHARGE_STEP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_off | input | 1 | System not ready or remote off; drains and clears |
| seq_en | input | 1 | Sequence enable; gates the timer latch |
| pbp_flag | input | 1 | Current above the lower (cycle-by-cycle) threshold |
| oneshot_flag | input | 1 | Current above the higher (short) threshold |
| lockout | output | 1 | Latched disable of all power outputs |
| ss_level | output | SS_W | Soft-start level in counter units |
| discharge | output | 1 | Level is being drained (off or short) |
| short_det | output | 1 | Short detected, held until level reaches LOW_TH |

## Verification
The bench builds the block with SS_W=12 and the 1 mV scale thresholds. It uses CHARGE_STEP=250, DISCH_STEP=300 and TMR_STEP=20, so a full ramp takes 16 clocks, a timer run from base to latch takes 6, and a drain from the clamp lands exactly on LOW_TH after 12. That last count makes the `<=` boundary on short release an exact hit rather than an overshoot. These steps also put every transition, including lockout from the timer, a sys_off drain to zero and a restart after a short, within a few hundred cycles. A behavioural model then compares all outputs each clock.

// File: rtl/ocp_sup_pkg.sv
// Shared types for the overcurrent / soft-start supervisor.
// Assumes: nothing beyond IEEE 1800-2017 enums and packed structs.
package ocp_sup_pkg;

    // Supervisor operating states
    typedef enum logic [2:0] {
        ST_OFF,    // system off / reset: draining
        ST_RAMP,   // soft start rising
        ST_CLAMP,  // level held at the clamp
        ST_TIMER,  // integrating sustained cycle-by-cycle limiting
        ST_SHORT,  // one-shot fault: draining to the low threshold
        ST_LOCK    // latched lockout
    } sup_state_t;

    // Operation requested of the level counter
    typedef enum logic [2:0] {
        LV_HOLD,
        LV_CHARGE,
        LV_INTEG,
        LV_DRAIN,
        LV_BASE,
        LV_TOP
    } lvl_op_t;

    // Threshold comparison results
    typedef struct packed {
        logic at_top;    // level >= clamp
        logic at_latch;  // level >= latch threshold
        logic at_low;    // level <= low threshold
    } lvl_cmp_t;

endpackage

// File: rtl/ss_level_ctr.sv
// Saturating soft-start level counter.
// Applies one operation per clock: hold, charge step, timer step, drain step,
// load timer base or load clamp. Up-steps saturate at SS_TOP, drain floors at 0.
// Assumes: SS_TOP < 2**SS_W, TMR_BASE <= SS_TOP, and the step sizes fit in SS_W bits.
module ss_level_ctr
    import ocp_sup_pkg::*;
#(
    parameter int SS_W        = 12,
    parameter int SS_TOP      = 4000,
    parameter int TMR_BASE    = 3780,
    parameter int CHARGE_STEP = 1,
    parameter int TMR_STEP    = 1,
    parameter int DISCH_STEP  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  lvl_op_t         op,
    output logic [SS_W-1:0] level
);
    localparam logic [SS_W:0]   TOP_X  = SS_TOP[SS_W:0];
    localparam logic [SS_W:0]   CHG_X  = CHARGE_STEP[SS_W:0];
    localparam logic [SS_W:0]   TMR_X  = TMR_STEP[SS_W:0];
    localparam logic [SS_W-1:0] DIS_V  = DISCH_STEP[SS_W-1:0];
    localparam logic [SS_W-1:0] TOP_V  = SS_TOP[SS_W-1:0];
    localparam logic [SS_W-1:0] BASE_V = TMR_BASE[SS_W-1:0];

    logic [SS_W:0]   chg_sum, tmr_sum;
    logic [SS_W-1:0] chg_sat, tmr_sat, drn_sat;

    // Saturated candidates for each arithmetic operation
    always_comb begin
        chg_sum = {1'b0, level} + CHG_X;
        tmr_sum = {1'b0, level} + TMR_X;
        chg_sat = (chg_sum >= TOP_X) ? TOP_V : chg_sum[SS_W-1:0];
        tmr_sat = (tmr_sum >= TOP_X) ? TOP_V : tmr_sum[SS_W-1:0];
        drn_sat = (level > DIS_V) ? (level - DIS_V) : '0;
    end

    // Level register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
        end else begin
            case (op)
                LV_CHARGE: level <= chg_sat;
                LV_INTEG:  level <= tmr_sat;
                LV_DRAIN:  level <= drn_sat;
                LV_BASE:   level <= BASE_V;
                LV_TOP:    level <= TOP_V;
                default:   level <= level;
            endcase
        end
    end
endmodule

// File: rtl/ocp_level_cmp.sv
// Compares the soft-start level with the clamp, latch and low thresholds.
// Assumes: thresholds fit in SS_W bits. Purely combinational.
module ocp_level_cmp
    import ocp_sup_pkg::*;
#(
    parameter int SS_W     = 12,
    parameter int SS_TOP   = 4000,
    parameter int LATCH_TH = 3900,
    parameter int LOW_TH   = 400
) (
    input  logic [SS_W-1:0] level,
    output lvl_cmp_t        cmp
);
    localparam logic [SS_W-1:0] TOP_V   = SS_TOP[SS_W-1:0];
    localparam logic [SS_W-1:0] LATCH_V = LATCH_TH[SS_W-1:0];
    localparam logic [SS_W-1:0] LOW_V   = LOW_TH[SS_W-1:0];

    // Threshold decode
    always_comb begin
        cmp.at_top   = (level >= TOP_V);
        cmp.at_latch = (level >= LATCH_V);
        cmp.at_low   = (level <= LOW_V);
    end
endmodule

// File: rtl/ocp_fault_fsm.sv
// Fault sequencing for the supervisor.
// Decides the next state and the counter operation from the flags and the
// threshold results of the current level. Priority: sys_off, then the latched
// lockout, then one-shot, then timer gating.
// Assumes: flags are already synchronous to clk.
module ocp_fault_fsm
    import ocp_sup_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sys_off,
    input  logic       seq_en,
    input  logic       pbp_flag,
    input  logic       oneshot_flag,
    input  lvl_cmp_t   cmp,
    output sup_state_t state,
    output lvl_op_t    op
);
    sup_state_t nxt;

    // Next state and counter operation
    always_comb begin
        nxt = state;
        op  = LV_HOLD;
        if (sys_off) begin
            nxt = ST_OFF;
            op  = LV_DRAIN;
        end else begin
            case (state)
                ST_OFF: nxt = ST_RAMP;
                ST_RAMP: begin
                    if (oneshot_flag)    nxt = ST_SHORT;
                    else if (cmp.at_top) nxt = ST_CLAMP;
                    else                 op  = LV_CHARGE;
                end
                ST_CLAMP: begin
                    if (oneshot_flag) begin
                        nxt = ST_SHORT;
                    end else if (pbp_flag && seq_en) begin
                        nxt = ST_TIMER;
                        op  = LV_BASE;
                    end
                end
                ST_TIMER: begin
                    if (oneshot_flag) begin
                        nxt = ST_SHORT;
                    end else if (!pbp_flag || !seq_en) begin
                        nxt = ST_CLAMP;
                        op  = LV_TOP;
                    end else if (cmp.at_latch) begin
                        nxt = ST_LOCK;
                    end else begin
                        op  = LV_INTEG;
                    end
                end
                ST_SHORT: begin
                    if (cmp.at_low) nxt = ST_RAMP;
                    else            op  = LV_DRAIN;
                end
                default: nxt = state;  // lockout holds everything
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end
endmodule

// File: rtl/ocp_ss_supervisor.sv
// Overcurrent and soft-start fault supervisor, top level.
// Ties the level counter, the threshold comparator and the fault sequencer
// together, and decodes lockout, discharge and short-detect from the state.
// Assumes: synchronous flags; thresholds ordered LOW_TH < TMR_BASE < LATCH_TH <= SS_TOP.
module ocp_ss_supervisor
    import ocp_sup_pkg::*;
#(
    parameter int SS_W        = 12,
    parameter int SS_TOP      = 4000,
    parameter int LATCH_TH    = 3900,
    parameter int TMR_BASE    = 3780,
    parameter int LOW_TH      = 400,
    parameter int CHARGE_STEP = 1,
    parameter int TMR_STEP    = 1,
    parameter int DISCH_STEP  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sys_off,
    input  logic            seq_en,
    input  logic            pbp_flag,
    input  logic            oneshot_flag,
    output logic            lockout,
    output logic [SS_W-1:0] ss_level,
    output logic            discharge,
    output logic            short_det
);
    localparam logic [SS_W-1:0] TOP_V = SS_TOP[SS_W-1:0];
    localparam logic [SS_W-1:0] LOW_V = LOW_TH[SS_W-1:0];

    sup_state_t state;
    lvl_op_t    op;
    lvl_cmp_t   cmp;

    ss_level_ctr #(
        .SS_W(SS_W), .SS_TOP(SS_TOP), .TMR_BASE(TMR_BASE),
        .CHARGE_STEP(CHARGE_STEP), .TMR_STEP(TMR_STEP), .DISCH_STEP(DISCH_STEP)
    ) u_ctr (
        .clk(clk), .rst_n(rst_n), .op(op), .level(ss_level)
    );

    ocp_level_cmp #(
        .SS_W(SS_W), .SS_TOP(SS_TOP), .LATCH_TH(LATCH_TH), .LOW_TH(LOW_TH)
    ) u_cmp (
        .level(ss_level), .cmp(cmp)
    );

    ocp_fault_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sys_off(sys_off), .seq_en(seq_en),
        .pbp_flag(pbp_flag), .oneshot_flag(oneshot_flag),
        .cmp(cmp), .state(state), .op(op)
    );

    // Output decode from the registered state
    always_comb begin
        lockout   = (state == ST_LOCK);
        short_det = (state == ST_SHORT);
        discharge = (state == ST_OFF) || (state == ST_SHORT);
    end

    // R3
    lvl_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ss_level <= TOP_V);

    // R2
    off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_off |=> (discharge && !lockout && !short_det));

    // R9
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lockout && !sys_off) |=> (lockout && $stable(ss_level)));

    // R10
    seq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_en && !lockout) |=> !lockout);

    // R4
    short_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        short_det |=> (ss_level <= $past(ss_level)));

    // R5
    short_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(short_det) && !$past(sys_off)) |-> (ss_level <= LOW_V));
endmodule

// File: tb/ocp_ss_supervisor_tb.sv
// Bench: behavioural reference model compared with the design every clock.
module ocp_ss_supervisor_tb;
    localparam int W = 12, TOP = 4000, LATCH = 3900, BASE = 3780, LOW = 400;
    localparam int CHG = 250, TMR = 20, DIS = 300;
    localparam int M_OFF = 0, M_RAMP = 1, M_CLAMP = 2, M_TIMER = 3, M_SHORT = 4, M_LOCK = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0, sys_off = 1'b1, seq_en = 1'b0, pbp_flag = 1'b0, oneshot_flag = 1'b0;
    logic lockout, discharge, short_det;
    logic [W-1:0] ss_level;

    int n_checks = 0, n_err = 0, cyc = 0;
    int m_st = M_OFF, m_lvl = 0;
    bit cmp_en = 0, done = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;  // 125 MHz

    ocp_ss_supervisor #(
        .SS_W(W), .SS_TOP(TOP), .LATCH_TH(LATCH), .TMR_BASE(BASE), .LOW_TH(LOW),
        .CHARGE_STEP(CHG), .TMR_STEP(TMR), .DISCH_STEP(DIS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .sys_off(sys_off), .seq_en(seq_en),
        .pbp_flag(pbp_flag), .oneshot_flag(oneshot_flag),
        .lockout(lockout), .ss_level(ss_level), .discharge(discharge), .short_det(short_det)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Reference model: requirement behaviour, one update per clock
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = M_OFF; m_lvl = 0;
        end else if (sys_off) begin
            m_st = M_OFF; m_lvl = (m_lvl > DIS) ? m_lvl - DIS : 0;
        end else begin
            case (m_st)
                M_OFF: m_st = M_RAMP;
                M_RAMP:
                    if (oneshot_flag) m_st = M_SHORT;
                    else if (m_lvl >= TOP) m_st = M_CLAMP;
                    else m_lvl = (m_lvl + CHG > TOP) ? TOP : m_lvl + CHG;
                M_CLAMP:
                    if (oneshot_flag) m_st = M_SHORT;
                    else if (pbp_flag && seq_en) begin m_st = M_TIMER; m_lvl = BASE; end
                M_TIMER:
                    if (oneshot_flag) m_st = M_SHORT;
                    else if (!pbp_flag || !seq_en) begin m_st = M_CLAMP; m_lvl = TOP; end
                    else if (m_lvl >= LATCH) m_st = M_LOCK;
                    else m_lvl = (m_lvl + TMR > TOP) ? TOP : m_lvl + TMR;
                M_SHORT:
                    if (m_lvl <= LOW) m_st = M_RAMP;
                    else m_lvl = (m_lvl > DIS) ? m_lvl - DIS : 0;
                default: ;
            endcase
        end
    end

    // Per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (cmp_en) begin
            check(cur_req, "ss_level", 32'(ss_level), 32'(m_lvl));
            check(cur_req, "lockout", 32'(lockout), 32'(m_st == M_LOCK));
            check(cur_req, "short_det", 32'(short_det), 32'(m_st == M_SHORT));
            check(cur_req, "discharge", 32'(discharge), 32'(m_st == M_OFF || m_st == M_SHORT));
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_err++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 20000);
            finish_run();
        end
    end

    initial begin
        wait_cyc(3);
        cmp_en = 1;
        cur_req = "R1";
        check("R1", "ss_level", 32'(ss_level), 0);
        check("R1", "lockout", 32'(lockout), 0);
        check("R1", "short_det", 32'(short_det), 0);
        check("R1", "discharge", 32'(discharge), 1);
        rst_n = 1'b1;
        wait_cyc(2);

        // Ramp with cycle-by-cycle flag early (ignored below the clamp)
        cur_req = "R3"; sys_off = 1'b0; seq_en = 1'b1;
        wait_cyc(3);
        cur_req = "R12"; pbp_flag = 1'b1;
        wait_cyc(4);
        check("R12", "lockout", 32'(lockout), 0);
        pbp_flag = 1'b0; cur_req = "R3";
        wait_cyc(14);
        check("R3", "ss_level", 32'(ss_level), TOP);

        // Flag with sequence disabled: no integration
        cur_req = "R10"; seq_en = 1'b0; pbp_flag = 1'b1;
        wait_cyc(10);
        check("R10", "ss_level", 32'(ss_level), TOP);
        check("R10", "lockout", 32'(lockout), 0);

        // Start integrating, then release the flag
        cur_req = "R6"; seq_en = 1'b1;
        wait_cyc(3);
        check("R6", "ss_level", 32'(ss_level), BASE + 2 * TMR);
        cur_req = "R7"; pbp_flag = 1'b0;
        wait_cyc(2);
        check("R7", "ss_level", 32'(ss_level), TOP);

        // Sequence drop during integration
        pbp_flag = 1'b1;
        wait_cyc(3);
        seq_en = 1'b0;
        wait_cyc(2);
        check("R7", "ss_level", 32'(ss_level), TOP);
        pbp_flag = 1'b0; seq_en = 1'b1;

        // One-shot short from the clamp, drain to the low threshold, restart
        cur_req = "R4"; oneshot_flag = 1'b1;
        wait_cyc(1);
        oneshot_flag = 1'b0;
        check("R4", "short_det", 32'(short_det), 1);
        check("R4", "discharge", 32'(discharge), 1);
        cur_req = "R5";
        wait_cyc(11);
        check("R5", "short_det", 32'(short_det), 1);
        wait_cyc(2);
        check("R5", "short_det", 32'(short_det), 0);
        wait_cyc(20);

        // Both flags together: one-shot wins
        cur_req = "R11"; oneshot_flag = 1'b1; pbp_flag = 1'b1;
        wait_cyc(1);
        oneshot_flag = 1'b0;
        check("R11", "short_det", 32'(short_det), 1);
        pbp_flag = 1'b0;
        wait_cyc(40);

        // One-shot during integration
        cur_req = "R4"; pbp_flag = 1'b1;
        wait_cyc(3);
        oneshot_flag = 1'b1;
        wait_cyc(1);
        oneshot_flag = 1'b0; pbp_flag = 1'b0;
        check("R4", "short_det", 32'(short_det), 1);
        wait_cyc(40);

        // Sustained limiting reaches the latch threshold
        cur_req = "R8"; pbp_flag = 1'b1;
        wait_cyc(12);
        check("R8", "lockout", 32'(lockout), 1);
        check("R8", "ss_level>=latch", 32'(ss_level >= LATCH), 1);

        // Flags released and a short while locked: lockout holds
        cur_req = "R9"; pbp_flag = 1'b0; oneshot_flag = 1'b1;
        wait_cyc(2);
        oneshot_flag = 1'b0; seq_en = 1'b0;
        wait_cyc(5);
        check("R9", "lockout", 32'(lockout), 1);
        check("R9", "short_det", 32'(short_det), 0);

        // System off drains and clears
        cur_req = "R2"; sys_off = 1'b1;
        wait_cyc(16);
        check("R2", "ss_level", 32'(ss_level), 0);
        check("R2", "lockout", 32'(lockout), 0);
        check("R2", "discharge", 32'(discharge), 1);
        cur_req = "R3"; sys_off = 1'b0; seq_en = 1'b1;
        wait_cyc(20);
        check("R3", "ss_level", 32'(ss_level), TOP);

        finish_run();
    end
endmodule